// File: doc/BRIEF.md
# Admission-Controlled Instruction Filter

This block sits between the instruction fetch path and a main LRU instruction cache. Each fetched block address first goes to a small fully associative filter. A lookup that hits there is served from the filter and becomes its most recently used entry. A lookup that misses both the filter and the main cache produces a refill request, and the block lands in the filter rather than in the main cache.

When the filter is full, a new block pushes out its least recently used entry. The block that leaves is either admitted to the main cache or bypassed. A two-level reuse predictor makes that choice. Low address bits select a per-address outcome history, and that history selects a 2-bit saturating counter. A single comparison slot remembers the victim together with the main-cache block it would displace. Whichever of the two is fetched first sets the outcome used to train the predictor.

The block stores only addresses. The main cache supplies its tag-hit result and its own replacement candidate, called the contender, on the same cycle as the lookup.

Top module: `icache_admit_filter`

## Requirements
- R1: After reset all outputs are 0, the filter is empty and every history is 0. Every counter is 1. A cycle with no lookup raises no output.
- R2: A lookup that matches a filter entry raises `hit_o` one cycle later, with no refill and no eviction, and makes that entry the most recently used.
- R3: A lookup that misses the filter while `mc_hit_i` is 1 raises neither `hit_o` nor a refill and does not insert the block, so a repeat of it still misses the filter.
- R4: A lookup that misses both raises `refill_req_o` one cycle later with `refill_addr_o` equal to the looked-up address, and inserts the block as most recently used.
- R5: The filter holds 16 blocks. An insertion into a full filter removes the least recently used entry and reports it on `evict_valid_o`/`evict_addr_o` in the same cycle as the refill. No eviction occurs while a slot is free.
- R6: Each eviction reports `admit_o` = 1 exactly when counter[history[victim address bits 3:0]] is 2 or more. Otherwise it reports bypass (0).
- R7: Each eviction with `mc_victim_valid_i` = 1 loads the comparison slot with the victim and the contender. A later lookup of the victim address trains outcome 1: the history shifts left taking 1 into bit 0, and the counter it indexed before the shift increments, saturating at 3.
- R8: A lookup of the contender address while the slot holds a pair trains outcome 0: the history shifts in 0 and the indexed counter decrements, saturating at 0. Either resolution empties the slot.
- R9: A new pair overwrites an unresolved pair without training on it. A later lookup of the overwritten victim changes no predictor state.
- R10: The admit decision for an eviction uses predictor state from before any training caused by the same lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid_i | input | 1 | Lookup strobe |
| lk_addr_i | input | AW | Block address looked up |
| mc_hit_i | input | 1 | Main cache tag hit for this lookup |
| mc_victim_valid_i | input | 1 | Main cache offers a replacement candidate |
| mc_victim_addr_i | input | AW | Address of that candidate (contender) |
| hit_o | output | 1 | Previous lookup hit the filter |
| refill_req_o | output | 1 | Previous lookup missed everywhere |
| refill_addr_o | output | AW | Address to refill |
| evict_valid_o | output | 1 | A block left the filter |
| evict_addr_o | output | AW | Address of the block that left |
| admit_o | output | 1 | 1 = admit to main cache, 0 = bypass |

## Verification
All results for a lookup are registered at the clock edge that samples the lookup, so every output is due one cycle later. The bench samples them on the following falling edge, before it drives the next lookup. Predictor training also takes effect at that edge, and only the next eviction that indexes the trained entry shows it. Directed sequences therefore count evictions by hand to place the training effects. This includes an eviction on the very lookup that trains, which must still see the old counter. A reference model written from the requirements checks a long pseudo-random stream cycle by cycle.

// File: rtl/icache_admit_filter.sv
module icache_admit_filter #(
  parameter int AW        = 32,
  parameter int ENTRIES   = 16,
  parameter int HIST_W    = 4,
  parameter int HRT_IDX_W = 4,
  parameter int CTR_W     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_valid_i,
  input  logic [AW-1:0] lk_addr_i,
  input  logic          mc_hit_i,
  input  logic          mc_victim_valid_i,
  input  logic [AW-1:0] mc_victim_addr_i,
  output logic          hit_o,
  output logic          refill_req_o,
  output logic [AW-1:0] refill_addr_o,
  output logic          evict_valid_o,
  output logic [AW-1:0] evict_addr_o,
  output logic          admit_o
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int HRT_N = 1 << HRT_IDX_W;
  localparam int PT_N  = 1 << HIST_W;
  localparam logic [CTR_W-1:0] CTR_MAX  = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(1);
  localparam logic [CTR_W-1:0] CTR_TH   = CTR_W'(1 << (CTR_W - 1));
  localparam logic [IDX_W-1:0] OLDEST   = IDX_W'(ENTRIES - 1);

  logic [AW-1:0]     tag_q [ENTRIES];
  logic [IDX_W-1:0]  age_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [HIST_W-1:0] hrt_q [HRT_N];
  logic [CTR_W-1:0]  pt_q  [PT_N];

  logic                 cs_valid_q;
  logic [AW-1:0]        cs_vic_q, cs_con_q;

  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   hit_idx, lru_idx, touch_idx;
  logic               hit_any, insert, touch, evict;

  always_comb begin
    hit_idx = '0;
    lru_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      match[i] = valid_q[i] && (tag_q[i] == lk_addr_i);
      if (match[i]) hit_idx = IDX_W'(i);
      if (age_q[i] == OLDEST) lru_idx = IDX_W'(i);
    end
  end

  assign hit_any   = |match;
  assign insert    = lk_valid_i && !hit_any && !mc_hit_i;
  assign touch     = (lk_valid_i && hit_any) || insert;
  assign touch_idx = hit_any ? hit_idx : lru_idx;
  assign evict     = insert && valid_q[lru_idx];

  logic [AW-1:0]     victim_addr;
  logic [HIST_W-1:0] vic_hist;
  logic              vic_admit;
  assign victim_addr = tag_q[lru_idx];
  assign vic_hist    = hrt_q[victim_addr[HRT_IDX_W-1:0]];
  assign vic_admit   = pt_q[vic_hist] >= CTR_TH;

  logic              res_vic, res_con, resolve;
  logic [HRT_IDX_W-1:0] tr_idx;
  logic [HIST_W-1:0] tr_hist;
  logic [CTR_W-1:0]  tr_ctr, tr_ctr_next;
  assign res_vic = lk_valid_i && cs_valid_q && (lk_addr_i == cs_vic_q);
  assign res_con = lk_valid_i && cs_valid_q && (lk_addr_i == cs_con_q) && !res_vic;
  assign resolve = res_vic || res_con;
  assign tr_idx  = cs_vic_q[HRT_IDX_W-1:0];
  assign tr_hist = hrt_q[tr_idx];
  assign tr_ctr  = pt_q[tr_hist];
  assign tr_ctr_next = res_vic ? ((tr_ctr == CTR_MAX) ? tr_ctr : tr_ctr + 1'b1)
                               : ((tr_ctr == '0) ? tr_ctr : tr_ctr - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_o         <= 1'b0;
      refill_req_o  <= 1'b0;
      refill_addr_o <= '0;
      evict_valid_o <= 1'b0;
      evict_addr_o  <= '0;
      admit_o       <= 1'b0;
      valid_q       <= '0;
      cs_valid_q    <= 1'b0;
      cs_vic_q      <= '0;
      cs_con_q      <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        age_q[i] <= IDX_W'(i);
      end
      for (int i = 0; i < HRT_N; i++) hrt_q[i] <= '0;
      for (int i = 0; i < PT_N; i++)  pt_q[i]  <= CTR_INIT;
    end else begin
      hit_o         <= lk_valid_i && hit_any;
      refill_req_o  <= insert;
      evict_valid_o <= evict;
      admit_o       <= evict && vic_admit;
      if (insert) refill_addr_o <= lk_addr_i;
      if (evict)  evict_addr_o  <= victim_addr;

      if (touch) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IDX_W'(i) == touch_idx)       age_q[i] <= '0;
          else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
        end
      end
      if (insert) begin
        tag_q[lru_idx]   <= lk_addr_i;
        valid_q[lru_idx] <= 1'b1;
      end

      if (resolve) begin
        hrt_q[tr_idx] <= {tr_hist[HIST_W-2:0], res_vic};
        pt_q[tr_hist] <= tr_ctr_next;
      end

      if (evict && mc_victim_valid_i) begin
        cs_valid_q <= 1'b1;
        cs_vic_q   <= victim_addr;
        cs_con_q   <= mc_victim_addr_i;
      end else if (resolve) begin
        cs_valid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/icache_admit_filter_chk.sv
module icache_admit_filter_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_valid_i,
  input logic [AW-1:0] lk_addr_i,
  input logic          mc_hit_i,
  input logic          hit_o,
  input logic          refill_req_o,
  input logic [AW-1:0] refill_addr_o,
  input logic          evict_valid_o,
  input logic          admit_o
);
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(lk_valid_i) |-> !(hit_o || refill_req_o || evict_valid_o));

  p_hit_no_refill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> !refill_req_o && !evict_valid_o);

  p_mc_hit_no_refill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lk_valid_i && mc_hit_i) |-> !refill_req_o);

  p_refill_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req_o |-> refill_addr_o == $past(lk_addr_i));

  p_evict_with_refill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid_o |-> refill_req_o);

  p_admit_needs_evict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    admit_o |-> evict_valid_o);
endmodule

bind icache_admit_filter icache_admit_filter_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_valid_i(lk_valid_i), .lk_addr_i(lk_addr_i),
  .mc_hit_i(mc_hit_i), .hit_o(hit_o), .refill_req_o(refill_req_o),
  .refill_addr_o(refill_addr_o), .evict_valid_o(evict_valid_o), .admit_o(admit_o)
);

// File: tb/icache_admit_filter_tb_top.sv
module icache_admit_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid_i, mc_hit_i, mc_victim_valid_i;
  logic [31:0] lk_addr_i, mc_victim_addr_i;
  logic        hit_o, refill_req_o, evict_valid_o, admit_o;
  logic [31:0] refill_addr_o, evict_addr_o;

  always #4 clk = ~clk;

  icache_admit_filter dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid_i(lk_valid_i), .lk_addr_i(lk_addr_i),
    .mc_hit_i(mc_hit_i), .mc_victim_valid_i(mc_victim_valid_i),
    .mc_victim_addr_i(mc_victim_addr_i), .hit_o(hit_o), .refill_req_o(refill_req_o),
    .refill_addr_o(refill_addr_o), .evict_valid_o(evict_valid_o),
    .evict_addr_o(evict_addr_o), .admit_o(admit_o)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] m_list [16];
  int          m_cnt;
  logic [3:0]  m_hist [16];
  logic [1:0]  m_ctr  [16];
  bit          m_cs_v;
  logic [31:0] m_cs_vic, m_cs_con;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic m_train(input bit o);
    logic [3:0] h;
    h = m_hist[m_cs_vic[3:0]];
    if (o && m_ctr[h] != 2'd3) m_ctr[h] = m_ctr[h] + 2'd1;
    if (!o && m_ctr[h] != 2'd0) m_ctr[h] = m_ctr[h] - 2'd1;
    m_hist[m_cs_vic[3:0]] = {h[2:0], o};
  endtask

  task automatic do_reset();
    rst_n = 1'b0; lk_valid_i = 0; lk_addr_i = 0; mc_hit_i = 0;
    mc_victim_valid_i = 0; mc_victim_addr_i = 0;
    repeat (3) @(negedge clk);
    m_cnt = 0; m_cs_v = 0; m_cs_vic = 0; m_cs_con = 0;
    for (int i = 0; i < 16; i++) begin m_hist[i] = 0; m_ctr[i] = 2'd1; m_list[i] = 0; end
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic lookup(input logic [31:0] a, input bit mh, input bit cvv, input logic [31:0] cva);
    int pos;
    bit e_hit, e_ref, e_ev, e_adm, res, o;
    logic [31:0] e_eva;
    pos = -1;
    for (int k = 0; k < m_cnt; k++) if (m_list[k] == a) pos = k;
    e_hit = pos >= 0; e_ref = 0; e_ev = 0; e_adm = 0; e_eva = 0;
    if (e_hit) begin
      for (int k = pos; k > 0; k--) m_list[k] = m_list[k-1];
      m_list[0] = a;
    end else if (!mh) begin
      e_ref = 1;
      if (m_cnt == 16) begin
        e_ev = 1; e_eva = m_list[15];
        e_adm = m_ctr[m_hist[e_eva[3:0]]] >= 2'd2;
        m_cnt--;
      end
      for (int k = m_cnt; k > 0; k--) m_list[k] = m_list[k-1];
      m_list[0] = a;
      m_cnt++;
    end
    res = 0; o = 0;
    if (m_cs_v && a == m_cs_vic) begin res = 1; o = 1; end
    else if (m_cs_v && a == m_cs_con) begin res = 1; o = 0; end
    if (res) m_train(o);
    if (e_ev && cvv) begin m_cs_v = 1; m_cs_vic = e_eva; m_cs_con = cva; end
    else if (res) m_cs_v = 0;

    lk_valid_i = 1; lk_addr_i = a; mc_hit_i = mh;
    mc_victim_valid_i = cvv; mc_victim_addr_i = cva;
    @(negedge clk);
    lk_valid_i = 0; mc_hit_i = 0; mc_victim_valid_i = 0;
    chk("R2 hit", {31'd0, hit_o}, {31'd0, e_hit});
    chk("R4 refill", {31'd0, refill_req_o}, {31'd0, e_ref});
    if (e_ref) chk("R4 refill addr", refill_addr_o, a);
    chk("R5 evict", {31'd0, evict_valid_o}, {31'd0, e_ev});
    if (e_ev) chk("R5 evict addr", evict_addr_o, e_eva);
    chk("R6 admit", {31'd0, admit_o}, {31'd0, e_adm});
  endtask

  task automatic t_reset_r1();
    do_reset();
    chk("R1 hit after reset", {31'd0, hit_o}, 0);
    chk("R1 refill after reset", {31'd0, refill_req_o}, 0);
    chk("R1 evict after reset", {31'd0, evict_valid_o}, 0);
    chk("R1 admit after reset", {31'd0, admit_o}, 0);
    lookup(32'h1000, 0, 0, 0);
    chk("R1 empty filter misses", {31'd0, refill_req_o}, 1);
    @(negedge clk);
    chk("R1 idle cycle quiet", {31'd0, hit_o | refill_req_o | evict_valid_o}, 0);
  endtask

  task automatic t_fill_hit_bypass_r3();
    do_reset();
    for (int i = 0; i < 16; i++) begin
      lookup(32'h1000 + i, 0, 0, 0);
      chk("R5 no evict while free", {31'd0, evict_valid_o}, 0);
    end
    lookup(32'h1003, 0, 0, 0);
    chk("R2 filled block hits", {31'd0, hit_o}, 1);
    lookup(32'h3000, 1, 0, 0);
    chk("R3 main hit no refill", {31'd0, refill_req_o}, 0);
    chk("R3 main hit no filter hit", {31'd0, hit_o}, 0);
    lookup(32'h3000, 1, 0, 0);
    chk("R3 block not inserted", {31'd0, hit_o}, 0);
    lookup(32'h3001, 0, 0, 0);
    chk("R5 LRU victim", evict_addr_o, 32'h1000);
    lookup(32'h3002, 0, 0, 0);
    chk("R5 refreshed entry skipped", evict_addr_o, 32'h1001);
    lookup(32'h3003, 0, 0, 0);
    chk("R5 next LRU victim", evict_addr_o, 32'h1002);
    lookup(32'h3004, 0, 0, 0);
    chk("R2 refresh moved 1003", evict_addr_o, 32'h1004);
  endtask

  task automatic t_training_r7_r8_r9_r10();
    do_reset();
    for (int i = 0; i < 16; i++) lookup(32'h1000 + i, 0, 0, 0);
    lookup(32'h2000, 0, 1, 32'hF000);
    chk("R6 initial bypass", {31'd0, admit_o}, 0);
    lookup(32'h1000, 0, 0, 0);
    chk("R10 same-cycle training unseen", {31'd0, admit_o}, 0);
    chk("R10 evicted 1001", evict_addr_o, 32'h1001);
    lookup(32'h2001, 0, 0, 0);
    chk("R7 victim-first leads to admit", {31'd0, admit_o}, 1);
    lookup(32'h2002, 0, 1, 32'hF001);
    chk("R7 admit persists", {31'd0, admit_o}, 1);
    lookup(32'hF001, 1, 0, 0);
    lookup(32'h2003, 0, 0, 0);
    chk("R8 contender-first leads to bypass", {31'd0, admit_o}, 0);
    lookup(32'h2004, 0, 1, 32'hF002);
    lookup(32'h2005, 0, 1, 32'hF003);
    lookup(32'h1005, 1, 0, 0);
    lookup(32'h2006, 0, 0, 0);
    chk("R9 overwritten pair not trained", {31'd0, admit_o}, 0);
    lookup(32'h1006, 1, 0, 0);
    lookup(32'h2007, 0, 0, 0);
    chk("R9 live pair trains", {31'd0, admit_o}, 1);
  endtask

  task automatic t_stress();
    logic [31:0] r;
    do_reset();
    r = 32'h2545F491;
    for (int n = 0; n < 3000; n++) begin
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      lookup(32'h4000 + (r % 40), ((r >> 16) % 5) == 0, ((r >> 20) % 8) != 0,
             32'h4000 + ((r >> 8) % 40));
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    @(negedge clk);
    t_reset_r1();
    t_fill_hit_bypass_r3();
    t_training_r7_r8_r9_r10();
    t_stress();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule